// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block keeps a small learning table for an Ethernet switch. Each entry is keyed by a 16-bit VLAN ID joined to a 48-bit MAC address and carries a destination field (an address value, a 2-bit address kind, a locked flag and a valid flag). A processor drives a simple word-addressed register port. It loads a key and an entry word, then writes a control word that names a command and sets a start bit. The engine runs the command against the table and clears the start bit when it is done. Results come back through the same key and entry registers.

Every command steps once through all entries and then spends one cycle applying its result. Run time is therefore fixed at one cycle per entry plus one. Software can install or remove an entry by key, test whether a key is present, read or write a slot by index, and walk the table in ascending key order with the find-next command. Find-next can optionally skip locked entries. It can also be narrowed to a single slot.

Top module: `mact_engine`

## Requirements
- R1: The register words are: 0 key-high (VLAN ID in bits 31:16, MAC byte 0 in 15:8, MAC byte 1 in 7:0), 1 key-low (MAC bytes 2 to 5, byte 2 in bits 31:24), 2 entry (bit 31 valid, bit 30 locked, bits 17:16 address kind, bits 11:0 address, other bits read 0), 3 scan options, 4 control, 5 status. The 64-bit key is {key-high, key-low}. After reset, every register reads 0 and the table is empty.
- R2: Writing word 4 with bit 0 at 1 starts the command held in bits 3:1 (0 learn, 1 unlearn, 2 lookup, 3 read, 4 write, 5 reserved, 6 find-next, 7 clear-all), using the slot index in bits 15:8. Bit 0 reads 1 while the command runs and returns to 0 within N+2 cycles of the write.
- R3: While bit 0 of word 4 reads 1, writes to any register are ignored, and that includes a new start.
- R4: Learn overwrites the valid entry whose key equals the loaded key. If there is no such entry, it fills the lowest-indexed invalid slot. The stored entry takes its address, kind and locked flag from the entry register, and its valid flag is set to 1.
- R5: Learn on a full table whose keys all differ from the loaded key leaves the table unchanged. It sets bit 0 of word 5, and that bit stays at 1 until reset.
- R6: Unlearn clears the slot holding the loaded key, so the slot then reads back with an all-zero entry word. If the key is absent, unlearn has no effect.
- R7: Lookup sets the entry register's valid bit to 1 and loads the stored fields when the key is present. When the key is absent, it clears only the valid bit. The key registers are not changed.
- R8: Read copies the key and entry of the indexed slot into the registers, including the slot's valid bit. Write stores the key registers and the entry word into that slot as they stand. When the index is N or above, read clears the valid bit and write does nothing.
- R9: Find-next selects, among valid entries, the one with the smallest key strictly greater than the loaded key, comparing both as unsigned 64-bit numbers. It loads that key and entry into the registers. If no entry qualifies, it clears the valid bit and leaves the key unchanged.
- R10: With bit 0 of word 3 at 1, find-next never returns a locked entry.
- R11: With bit 1 of word 3 at 0, find-next looks only at the slot named by the slot index. With that bit at 1, it looks at every slot.
- R12: Clear-all makes every slot invalid. Command code 5 changes no register and no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Register word written |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 3 | Register word read |
| bus_rdata | output | 32 | Read data for bus_raddr, combinational |

## Verification
A corrupted slot or a stale valid flag shows up at the register port on the next lookup, read or find-next that touches the slot. The result appears as soon as the start bit drops, which is N+1 cycles after the command. A bad ordering comparison gives a wrong key on the next step of a table walk. A lost learn on a full table shows up in the sticky status bit right after that command. The bench keeps a slot-exact model of the table, so a misplaced slot choice on learn is caught by the next read of that slot.

// File: rtl/mact_pkg.sv
package mact_pkg;

  parameter int unsigned ENT_ADDR_W = 12;
  localparam int unsigned SLOT_W    = 8;
  localparam int unsigned KEY_W     = 64;

  localparam logic [2:0] RW_KEY_HI = 3'd0;
  localparam logic [2:0] RW_KEY_LO = 3'd1;
  localparam logic [2:0] RW_ENTRY  = 3'd2;
  localparam logic [2:0] RW_SCFG   = 3'd3;
  localparam logic [2:0] RW_CTRL   = 3'd4;
  localparam logic [2:0] RW_STAT   = 3'd5;

  typedef enum logic [2:0] {
    CMD_LEARN   = 3'd0,
    CMD_UNLEARN = 3'd1,
    CMD_LOOKUP  = 3'd2,
    CMD_READ    = 3'd3,
    CMD_WRITE   = 3'd4,
    CMD_RSVD    = 3'd5,
    CMD_FIND    = 3'd6,
    CMD_CLEAR   = 3'd7
  } mact_cmd_e;

  typedef struct packed {
    logic                  vld;
    logic                  lck;
    logic [1:0]            kind;
    logic [ENT_ADDR_W-1:0] addr;
  } mact_ent_t;

  // Entry word layout: [31] valid, [30] locked, [17:16] kind, [11:0] address
  function automatic logic [31:0] ent_to_word(mact_ent_t e);
    logic [31:0] w;
    w = '0;
    w[31] = e.vld;
    w[30] = e.lck;
    w[17:16] = e.kind;
    w[ENT_ADDR_W-1:0] = e.addr;
    return w;
  endfunction

  function automatic mact_ent_t word_to_ent(logic [31:0] w);
    mact_ent_t e;
    e.vld  = w[31];
    e.lck  = w[30];
    e.kind = w[17:16];
    e.addr = w[ENT_ADDR_W-1:0];
    return e;
  endfunction

  // Unsigned 64-bit ordering of {VID, MAC}
  function automatic logic key_above(logic [KEY_W-1:0] cand, logic [KEY_W-1:0] base);
    return cand > base;
  endfunction

  function automatic logic key_below(logic [KEY_W-1:0] cand, logic [KEY_W-1:0] base);
    return cand < base;
  endfunction

endpackage

// File: rtl/mact_store.sv
module mact_store
  import mact_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  mact_ent_t        wr_ent,
  input  logic             clr_all,
  input  logic [IW-1:0]    a_idx,
  output logic [KEY_W-1:0] a_key,
  output logic             a_vld,
  output logic             a_lck,
  input  logic [IW-1:0]    b_idx,
  output logic [KEY_W-1:0] b_key,
  output mact_ent_t        b_ent
);

  logic [KEY_W-1:0] keys [N_ENTRIES];
  mact_ent_t        ents [N_ENTRIES];
  logic [N_ENTRIES-1:0] vld_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        keys[i] <= '0;
        ents[i] <= '0;
      end
    end else if (clr_all) begin
      for (int i = 0; i < N_ENTRIES; i++) ents[i].vld <= 1'b0;
    end else if (wr_en) begin
      keys[wr_idx] <= wr_key;
      ents[wr_idx] <= wr_ent;
    end
  end

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_vld
      assign vld_vec[g] = ents[g].vld;
    end
  endgenerate

  assign a_key = keys[a_idx];
  assign a_vld = ents[a_idx].vld;
  assign a_lck = ents[a_idx].lck;
  assign b_key = keys[b_idx];
  assign b_ent = ents[b_idx];

  // R12: one cycle after a clear-all no slot is valid
  a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_vec == '0));

  // R4: a write and a clear never happen in the same cycle
  a_r4_single_update: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_all && wr_en));

endmodule

// File: rtl/mact_scan.sv
module mact_scan
  import mact_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             active,
  input  logic [IW-1:0]    idx,
  input  logic [KEY_W-1:0] cand_key,
  input  logic             cand_vld,
  input  logic             cand_lck,
  input  logic [KEY_W-1:0] ref_key,
  input  logic             ign_lck,
  input  logic             until_fnd,
  input  logic             slot_ok,
  input  logic [IW-1:0]    slot_sel,
  output logic             hit,
  output logic [IW-1:0]    hit_idx,
  output logic             fr_found,
  output logic [IW-1:0]    fr_idx,
  output logic             best,
  output logic [IW-1:0]    best_idx
);

  logic [KEY_W-1:0] best_key;
  logic             best_lck;
  logic             cand_eq, cand_elig, cand_better;

  assign cand_eq     = cand_vld && (cand_key == ref_key);
  assign cand_elig   = cand_vld && key_above(cand_key, ref_key)
                       && !(ign_lck && cand_lck)
                       && (until_fnd || (slot_ok && (slot_sel == idx)));
  assign cand_better = !best || key_below(cand_key, best_key);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hit      <= 1'b0;
      hit_idx  <= '0;
      fr_found <= 1'b0;
      fr_idx   <= '0;
      best     <= 1'b0;
      best_idx <= '0;
      best_key <= '0;
      best_lck <= 1'b0;
    end else if (step) begin
      if (!hit && cand_eq) begin
        hit     <= 1'b1;
        hit_idx <= idx;
      end
      if (!fr_found && !cand_vld) begin
        fr_found <= 1'b1;
        fr_idx   <= idx;
      end
      if (cand_elig && cand_better) begin
        best     <= 1'b1;
        best_idx <= idx;
        best_key <= cand_key;
        best_lck <= cand_lck;
      end
    end
  end

  // R9: the running candidate is always strictly above the loaded key
  a_r9_best_above: assert property (@(posedge clk) disable iff (!rst_n)
    (active && best) |-> (best_key > ref_key));

  // R10: with the skip option on, a locked entry is never held as candidate
  a_r10_skip_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (active && best && ign_lck) |-> !best_lck);

endmodule

// File: rtl/mact_engine.sv
module mact_engine
  import mact_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_waddr,
  input  logic [31:0] bus_wdata,
  input  logic [2:0]  bus_raddr,
  output logic [31:0] bus_rdata
);

  localparam int unsigned IW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam logic [IW-1:0] CNT_LAST = IW'(N_ENTRIES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COMMIT} st_e;

  st_e              state;
  logic [IW-1:0]    cnt;
  logic [31:0]      key_hi, key_lo;
  mact_ent_t        ent_q;
  logic             cfg_ign, cfg_uf;
  mact_cmd_e        cmd_q;
  logic [SLOT_W-1:0] slot_q;
  logic             ovf_q;

  logic             busy, wr_ok, start_evt, slot_ok;
  logic [IW-1:0]    slot_idx;
  logic [KEY_W-1:0] ref_key;

  // table and scan wiring
  logic             tbl_we, tbl_clr;
  logic [IW-1:0]    tbl_widx, b_idx;
  logic [KEY_W-1:0] tbl_wkey, a_key, b_key;
  mact_ent_t        tbl_went, b_ent;
  logic             a_vld, a_lck;
  logic             hit, fr_found, best;
  logic [IW-1:0]    hit_idx, fr_idx, best_idx;

  assign busy      = (state != ST_IDLE);
  assign wr_ok     = bus_we && !busy;
  assign start_evt = wr_ok && (bus_waddr == RW_CTRL) && bus_wdata[0];
  assign slot_ok   = (int'(slot_q) < int'(N_ENTRIES));
  assign slot_idx  = slot_q[IW-1:0];
  assign ref_key   = {key_hi, key_lo};

  mact_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_widx),
    .wr_key  (tbl_wkey),
    .wr_ent  (tbl_went),
    .clr_all (tbl_clr),
    .a_idx   (cnt),
    .a_key   (a_key),
    .a_vld   (a_vld),
    .a_lck   (a_lck),
    .b_idx   (b_idx),
    .b_key   (b_key),
    .b_ent   (b_ent)
  );

  mact_scan #(.N_ENTRIES(N_ENTRIES)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_evt),
    .step      (state == ST_SCAN),
    .active    (busy),
    .idx       (cnt),
    .cand_key  (a_key),
    .cand_vld  (a_vld),
    .cand_lck  (a_lck),
    .ref_key   (ref_key),
    .ign_lck   (cfg_ign),
    .until_fnd (cfg_uf),
    .slot_ok   (slot_ok),
    .slot_sel  (slot_idx),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .fr_found  (fr_found),
    .fr_idx    (fr_idx),
    .best      (best),
    .best_idx  (best_idx)
  );

  // Commit-cycle table update and result read selection
  always_comb begin
    tbl_we   = 1'b0;
    tbl_clr  = 1'b0;
    tbl_widx = hit_idx;
    tbl_wkey = ref_key;
    tbl_went = ent_q;
    case (cmd_q)
      CMD_READ: b_idx = slot_idx;
      CMD_FIND: b_idx = best_idx;
      default:  b_idx = hit_idx;
    endcase
    if (state == ST_COMMIT) begin
      case (cmd_q)
        CMD_LEARN: begin
          tbl_we       = hit || fr_found;
          tbl_widx     = hit ? hit_idx : fr_idx;
          tbl_went.vld = 1'b1;
        end
        CMD_UNLEARN: begin
          tbl_we   = hit;
          tbl_went = '0;
        end
        CMD_WRITE: begin
          tbl_we   = slot_ok;
          tbl_widx = slot_idx;
        end
        CMD_CLEAR: tbl_clr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      key_hi  <= '0;
      key_lo  <= '0;
      ent_q   <= '0;
      cfg_ign <= 1'b0;
      cfg_uf  <= 1'b0;
      cmd_q   <= CMD_LEARN;
      slot_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (bus_waddr)
          RW_KEY_HI: key_hi <= bus_wdata;
          RW_KEY_LO: key_lo <= bus_wdata;
          RW_ENTRY:  ent_q  <= word_to_ent(bus_wdata);
          RW_SCFG: begin
            cfg_ign <= bus_wdata[0];
            cfg_uf  <= bus_wdata[1];
          end
          RW_CTRL: begin
            cmd_q  <= mact_cmd_e'(bus_wdata[3:1]);
            slot_q <= bus_wdata[15:8];
          end
          default: ;
        endcase
      end
      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            state <= ST_SCAN;
            cnt   <= '0;
          end
        end
        ST_SCAN: begin
          if (cnt == CNT_LAST) state <= ST_COMMIT;
          else                 cnt   <= cnt + 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          case (cmd_q)
            CMD_LEARN: if (!hit && !fr_found) ovf_q <= 1'b1;
            CMD_LOOKUP: begin
              if (hit) ent_q     <= b_ent;
              else     ent_q.vld <= 1'b0;
            end
            CMD_READ: begin
              if (slot_ok) begin
                {key_hi, key_lo} <= b_key;
                ent_q            <= b_ent;
              end else begin
                ent_q.vld <= 1'b0;
              end
            end
            CMD_FIND: begin
              if (best) begin
                {key_hi, key_lo} <= b_key;
                ent_q            <= b_ent;
              end else begin
                ent_q.vld <= 1'b0;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_comb begin
    case (bus_raddr)
      RW_KEY_HI: bus_rdata = key_hi;
      RW_KEY_LO: bus_rdata = key_lo;
      RW_ENTRY:  bus_rdata = ent_to_word(ent_q);
      RW_SCFG:   bus_rdata = {30'd0, cfg_uf, cfg_ign};
      RW_CTRL:   bus_rdata = {16'd0, slot_q, 4'd0, cmd_q, busy};
      RW_STAT:   bus_rdata = {31'd0, ovf_q};
      default:   bus_rdata = '0;
    endcase
  end

  // Busy-length counter for the bounded-completion check
  int unsigned busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_len <= 0;
    else                 busy_len <= busy_len + 1;
  end

  // R2: a start is followed by busy, and busy lasts at most N+1 cycles
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_len <= N_ENTRIES + 1));

  // R3: writes during a running command leave command and options alone
  a_r3_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_we) |=> ($stable(cmd_q) && $stable(slot_q) && $stable(cfg_ign) && $stable(cfg_uf)));

  // R5: overflow is sticky
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R7: lookup never alters the key registers
  a_r7_lookup_key: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMMIT && cmd_q == CMD_LOOKUP) |=> $stable(ref_key));

endmodule

// File: tb/test_mact_engine.sv
module test_mact_engine;
  import mact_pkg::*;

  localparam int N = 16;
  localparam logic [31:0] ENT_MASK = 32'hC003_0FFF;
  localparam logic [31:0] VBIT = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0]  bus_raddr = '0;
  logic [31:0] bus_rdata;

  always #10 clk = ~clk;

  mact_engine #(.N_ENTRIES(N)) i_mact_engine (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [63:0] m_key [N];
  logic [31:0] m_w   [N];
  logic        m_ovf, m_ign, m_uf;
  logic [63:0] rk;
  logic [31:0] rent;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_key[i] = '0; m_w[i] = '0; end
    m_ovf = 0; m_ign = 0; m_uf = 0; rk = '0; rent = '0;
  endtask

  task automatic set_key(input logic [63:0] k);
    wr(RW_KEY_HI, k[63:32]); wr(RW_KEY_LO, k[31:0]); rk = k;
  endtask

  task automatic set_ent(input logic [31:0] w);
    wr(RW_ENTRY, w); rent = w & ENT_MASK;
  endtask

  task automatic set_cfg(input logic ign, input logic uf);
    wr(RW_SCFG, {30'd0, uf, ign}); m_ign = ign; m_uf = uf;
  endtask

  // Expected effect of a command, from the requirements
  task automatic model_apply(input int cmd, input int slot);
    int hit, fr, bst;
    hit = -1; fr = -1; bst = -1;
    for (int i = 0; i < N; i++) begin
      if (m_w[i][31] && m_key[i] == rk && hit < 0) hit = i;
      if (!m_w[i][31] && fr < 0) fr = i;
      if (m_w[i][31] && m_key[i] > rk && !(m_ign && m_w[i][30]) && (m_uf || slot == i))
        if (bst < 0 || m_key[i] < m_key[bst]) bst = i;
    end
    case (cmd)
      0: if (hit >= 0) m_w[hit] = rent | VBIT;
         else if (fr >= 0) begin m_key[fr] = rk; m_w[fr] = rent | VBIT; end
         else m_ovf = 1;
      1: if (hit >= 0) m_w[hit] = '0;
      2: if (hit >= 0) rent = m_w[hit]; else rent[31] = 1'b0;
      3: if (slot < N) begin rk = m_key[slot]; rent = m_w[slot]; end else rent[31] = 1'b0;
      4: if (slot < N) begin m_key[slot] = rk; m_w[slot] = rent; end
      6: if (bst >= 0) begin rk = m_key[bst]; rent = m_w[bst]; end else rent[31] = 1'b0;
      7: for (int i = 0; i < N; i++) m_w[i][31] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    int n;
    n = 0;
    rd(RW_CTRL, v);
    chk(v[0] == 1'b1, {tag, " R2 busy after start"}, {63'd0, v[0]}, 64'd1);
    while (v[0] && n < 200) begin
      n++;
      @(negedge clk);
      rd(RW_CTRL, v);
    end
    chk(n >= 1 && n <= N + 2, {tag, " R2 completion bound"}, n, N + 1);
  endtask

  task automatic compare_all(input string tag);
    logic [31:0] h, l, e, s;
    rd(RW_KEY_HI, h); rd(RW_KEY_LO, l); rd(RW_ENTRY, e); rd(RW_STAT, s);
    chk({h, l} == rk, {tag, " key"}, {h, l}, rk);
    chk(e == rent, {tag, " entry"}, {32'd0, e}, {32'd0, rent});
    chk(s[0] == m_ovf, {tag, " R5 overflow bit"}, {63'd0, s[0]}, {63'd0, m_ovf});
  endtask

  task automatic exec(input int cmd, input int slot, input string tag);
    wr(RW_CTRL, {16'd0, 8'(slot), 4'd0, 3'(cmd), 1'b1});
    wait_done(tag);
    model_apply(cmd, slot);
    compare_all(tag);
  endtask

  function automatic string tag_of(input int cmd);
    case (cmd)
      0: return "R4 learn";
      1: return "R6 unlearn";
      2: return "R7 lookup";
      3: return "R8 read";
      4: return "R8 write";
      6: return "R9 find";
      7: return "R12 clear";
      default: return "R12 reserved";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  logic [63:0] k1, k2, k3, kw;
  logic [31:0] v;

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();

    // R1: reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 32'd0, "R1 reset register", {32'd0, v}, 64'd0);
    end

    k1 = {16'd5, 48'h0011_2233_4455};
    k2 = {16'd2, 48'h00AA_BBCC_DDEE};
    k3 = {16'd5, 48'h0011_2233_4400};
    set_cfg(1'b0, 1'b1);

    // R4: install and overwrite
    set_key(k1); set_ent(32'h0001_0005);
    exec(0, 0, "R4 learn new");
    exec(2, 0, "R7 lookup hit");
    set_ent(32'h4002_0007);
    exec(0, 0, "R4 learn overwrite");
    exec(3, 0, "R8 read slot0");
    chk(rk == k1, "R8 read slot0 key", rk, k1);
    set_key(k2); set_ent(32'h4003_0123);
    exec(0, 0, "R4 learn locked");
    set_key(k3); set_ent(32'h0000_0042);
    exec(0, 0, "R4 learn third");

    // R9: ordered walk
    set_key(64'd0);
    exec(6, 0, "R9 find first");
    chk(rk == k2, "R9 first is smallest", rk, k2);
    exec(6, 0, "R9 find second");
    chk(rk == k3, "R9 second key", rk, k3);
    exec(6, 0, "R9 find third");
    exec(6, 0, "R9 find past end");
    chk(rent[31] == 1'b0, "R9 none valid bit", {63'd0, rent[31]}, 64'd0);

    // R10: skip locked entries (k1 and k2 locked)
    set_cfg(1'b1, 1'b1); set_key(64'd0);
    exec(6, 0, "R10 skip locked");
    chk(rk == k3, "R10 first unlocked", rk, k3);
    exec(6, 0, "R10 none left");

    // R11: single-slot restriction
    set_cfg(1'b0, 1'b0); set_key(64'd0);
    exec(6, 0, "R11 slot0 only");
    chk(rk == k1, "R11 slot0 key", rk, k1);
    set_key(64'd0);
    exec(6, 3, "R11 empty slot");
    exec(6, 20, "R11 slot out of range");
    set_cfg(1'b0, 1'b1);

    // R6 / R7
    set_key(k2);
    exec(1, 0, "R6 unlearn");
    exec(2, 0, "R7 lookup miss");
    exec(1, 0, "R6 unlearn absent");
    exec(3, 1, "R6 slot reads cleared");

    // R8: direct write/read, out of range
    kw = {16'hFFFF, 48'h1234_5678_9ABC};
    set_key(kw); set_ent(32'hC001_0ABC);
    exec(4, 5, "R8 write slot5");
    set_key(64'd0); set_ent(32'd0);
    exec(3, 5, "R8 read slot5");
    chk(rk == kw, "R8 slot5 key", rk, kw);
    exec(3, 20, "R8 read out of range");
    exec(4, 17, "R8 write out of range");

    // R3: writes while busy are ignored (including a new clear-all start)
    set_key(k3);
    wr(RW_CTRL, {16'd0, 8'd0, 4'd0, 3'd2, 1'b1});
    wr(RW_KEY_HI, 32'hDEAD_BEEF);
    wr(RW_CTRL, {16'd0, 8'd0, 4'd0, 3'd7, 1'b1});
    wr(RW_SCFG, 32'd3);
    wait_done("R3 busy writes");
    model_apply(2, 0);
    compare_all("R3 busy writes");
    rd(RW_SCFG, v);
    chk(v == 32'd2, "R3 options unchanged", {32'd0, v}, 64'd2);
    exec(2, 0, "R3 table not cleared");
    chk(rent[31] == 1'b1, "R3 entry survives", {63'd0, rent[31]}, 64'd1);

    // R12: reserved code, then clear-all
    exec(5, 0, "R12 reserved");
    exec(2, 0, "R12 reserved lookup");
    exec(7, 0, "R12 clear");
    exec(2, 0, "R12 lookup after clear");
    chk(rent[31] == 1'b0, "R12 cleared lookup", {63'd0, rent[31]}, 64'd0);
    set_key(64'd0);
    exec(6, 0, "R12 find after clear");

    // Random mix
    for (int it = 0; it < 260; it++) begin
      int r, cmd, slot;
      logic [63:0] k;
      r = $urandom_range(0, 99);
      k = {16'($urandom_range(1, 3)), 16'h0011, 24'd0, 8'($urandom_range(0, 5))};
      slot = $urandom_range(0, 17);
      if (r < 30) begin cmd = 0; set_ent($urandom()); end
      else if (r < 45) cmd = 1;
      else if (r < 65) cmd = 2;
      else if (r < 85) begin cmd = 6; set_cfg(1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0)); end
      else if (r < 93) cmd = 3;
      else if (r < 98) begin cmd = 4; set_ent($urandom()); end
      else cmd = 7;
      if (cmd != 6 || $urandom_range(0, 1) == 1) set_key(k);
      exec(cmd, slot, tag_of(cmd));
    end

    // Full walk of the table
    set_cfg(1'b0, 1'b1); set_key(64'd0);
    for (int w = 0; w <= N; w++) begin
      exec(6, 0, "R9 walk");
      if (rent[31] == 1'b0) break;
    end

    // R5: full table overflow, from a fresh reset
    do_reset();
    set_cfg(1'b0, 1'b1);
    for (int i = 0; i < N; i++) begin
      set_key({16'd9, 48'(i)}); set_ent(32'(i));
      exec(0, 0, "R4 fill");
    end
    set_key({16'd9, 48'hFFFF}); set_ent(32'h0000_0FFF);
    exec(0, 0, "R5 learn on full");
    chk(m_ovf == 1'b1, "R5 model expects overflow", {63'd0, m_ovf}, 64'd1);
    exec(2, 0, "R5 new key absent");
    chk(rent[31] == 1'b0, "R5 not installed", {63'd0, rent[31]}, 64'd0);
    set_key({16'd9, 48'd3}); set_ent(32'h0000_0777);
    exec(0, 0, "R5 overwrite while full");
    exec(3, 3, "R5 slot3 after overwrite");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule